// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the two low-order address bits of a four-beat memory burst. When a burst begins, the caller pulses a load input together with the two low bits of the externally supplied address. That value becomes the first address of the burst. Each following cycle in which the active-low step input is asserted moves the sequencer to the next beat. A cycle with the step input high is a wait cycle, and the current address is kept.

A static order select input picks the order of the beats. With it low, the order is linear: the address is the start value plus the beat count, modulo four. With it high, the order is interleaved: the address is the start value XOR the beat count. A burst covers four addresses. The first comes from outside and the other three are generated here. Further steps keep cycling through the same four addresses. The sequencer also reports the beat index, which is the count of steps since the last load.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no load yet, `beat_idx` is 00 and `burst_addr` is 00.
- R2: In the cycle after a rising clock edge with `load` high, `burst_addr` equals the `start_addr` sampled at that edge, and `beat_idx` is 00.
- R3: With `order_sel` = 0 (linear), each step adds 1 modulo 4 to `burst_addr`. From start 01 the addresses are 01, 10, 11, 00.
- R4: With `order_sel` = 1 (interleaved), `burst_addr` equals the start value XOR `beat_idx`. From start 01 the addresses are 01, 00, 11, 10. From start 10 they are 10, 11, 00, 01.
- R5: An edge with `load` low and `step_n` high changes neither `burst_addr` nor `beat_idx`.
- R6: Each edge with `load` low and `step_n` low increments `beat_idx` by one modulo 4. After the fourth beat the same four addresses repeat.
- R7: When `load` and `step_n` = 0 occur at the same edge, the load wins: the start value is taken and `beat_idx` becomes 00.
- R8: `order_sel` acts combinationally. Changing it re-maps `burst_addr` from the same start and beat without a clock edge, and leaves `beat_idx` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Starts a burst from `start_addr` |
| start_addr | input | 2 | Low two bits of the external start address |
| step_n | input | 1 | Active-low advance; high means wait |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| burst_addr | output | 2 | Current low two bits of the burst address |
| beat_idx | output | 2 | Steps taken since the last load, modulo 4 |

## Verification
Every one of the four start values is run through a full burst plus one wrap beat, in both orders. Start values 01 and 11 separate the two orders: XOR and addition give different second and fourth addresses for them. Start 00 gives identical linear and interleaved sequences, so it only confirms that the count advances. Directed cases then show a wait cycle, a load and a step at the same edge, and a change of order partway through a burst. These expose any hold, priority or latching fault.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic          step_n,
  input  logic          order_sel,
  output logic [AW-1:0] burst_addr,
  output logic [AW-1:0] beat_idx
);

  logic [AW-1:0] base_q;
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= start_addr;
      cnt_q  <= '0;
    end else if (!step_n) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign beat_idx   = cnt_q;
  assign burst_addr = order_sel ? (base_q ^ cnt_q) : (base_q + cnt_q);

  // R2
  load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (burst_addr == $past(start_addr)) && (beat_idx == '0));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step_n) |=> $stable(beat_idx) && $stable(burst_addr));

  // R6
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n) |=> beat_idx == $past(beat_idx) + 1'b1);

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n && !order_sel) |=> (order_sel || burst_addr == $past(burst_addr) + 1'b1));

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !step_n) |=> beat_idx == '0);

endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
  logic clk = 0, rst_n = 0, load = 0, step_n = 1, order_sel = 0;
  logic [1:0] start_addr = 0;
  logic [1:0] burst_addr, beat_idx;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  burst_seq u_dut (.clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
                   .step_n(step_n), .order_sel(order_sel),
                   .burst_addr(burst_addr), .beat_idx(beat_idx));

  // {order_sel, start, addr0, addr1, addr2, addr3}
  localparam logic [10:0] VEC [8] = '{
    11'b0_00_00_01_10_11, 11'b0_01_01_10_11_00,
    11'b0_10_10_11_00_01, 11'b0_11_11_00_01_10,
    11'b1_00_00_01_10_11, 11'b1_01_01_00_11_10,
    11'b1_10_10_11_00_01, 11'b1_11_11_10_01_00
  };

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick; tick;
    chk("R1 addr in reset", burst_addr, 2'b00);
    chk("R1 beat in reset", beat_idx, 2'b00);
    rst_n = 1;
    tick;
    chk("R1 addr after reset", burst_addr, 2'b00);
    chk("R1 beat after reset", beat_idx, 2'b00);

    for (int v = 0; v < 8; v++) begin
      order_sel = VEC[v][10]; start_addr = VEC[v][9:8]; load = 1; step_n = 1;
      tick;
      load = 0;
      chk("R2 first addr", burst_addr, VEC[v][7:6]);
      chk("R2 beat zero", beat_idx, 2'b00);
      step_n = 0;
      for (int b = 1; b < 5; b++) begin
        tick;
        chk(VEC[v][10] ? "R4 interleaved beat" : "R3 linear beat",
            burst_addr, VEC[v][7 - 2*(b%4) -: 2]);
        chk("R6 beat index", beat_idx, 2'(b));
      end
      step_n = 1;
    end

    // R5 wait cycles
    order_sel = 0; start_addr = 2'b10; load = 1; tick; load = 0;
    step_n = 0; tick; step_n = 1; tick; tick;
    chk("R5 hold addr", burst_addr, 2'b11);
    chk("R5 hold beat", beat_idx, 2'b01);

    // R7 load beats step
    step_n = 0; tick;
    start_addr = 2'b01; load = 1; step_n = 0; tick; load = 0; step_n = 1;
    chk("R7 load wins addr", burst_addr, 2'b01);
    chk("R7 load wins beat", beat_idx, 2'b00);

    // R8 mode re-maps combinationally
    start_addr = 2'b11; load = 1; tick; load = 0;
    step_n = 0; tick; step_n = 1;
    #1; chk("R8 linear view", burst_addr, 2'b00);
    order_sel = 1; #1;
    chk("R8 interleaved view", burst_addr, 2'b10);
    chk("R8 beat unchanged", beat_idx, 2'b01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule